// File: doc/BRIEF.md
# Exhaustive DES Key Search Engine

This block recovers a DES key by brute force from one known plaintext block and its ciphertext. The host first loads the two 64-bit blocks while the unit is idle. It then starts a search by giving a key-space prefix, which fixes the upper bits of the 56-bit key. Internal counters walk every value of the remaining low key bits.

The low key field is divided among `N_ENG` parallel encryption pipelines. Each pipeline owns a fixed engine number that fills the top `log2(N_ENG)` bits of the low field, and its own counter fills the rest. All counters step together, so the unit tests `N_ENG` keys per clock. Each pipeline has 18 stages: an input register, sixteen round registers and an output register. The candidate key travels with its block down the pipeline. A match at the output therefore names the key that produced it. The search stops at the first match. If no key matches, the unit reports not-found once the last candidate has left the pipelines. The result stays on the outputs until the next search is accepted.

With default parameters the prefix is 24 bits wide and the low field is 32 bits wide. A test configuration can move the split between the two fields, as long as their widths still add up to 56.

Top module: `des_key_searcher`

## Requirements
- R1: After reset, `busy`, `done` and `found` are all 0.
- R2: The candidate key is the concatenation {prefix, engine number (log2(N_ENG) bits), engine counter (LOW_W - log2(N_ENG) bits)}, with the prefix in the most significant position. The key is standard DES with an odd-parity bit added at the least significant position of each key byte. On a match, `key` reports this 56-bit value.
- R3: A search whose matching key has counter value c raises `done` and `found` on the 19+c-th rising edge after the edge that accepted `start`. `done` is 0 on the edge before that.
- R4: With no matching key, `done` rises with `found` = 0 on the 19+M-th edge after acceptance, where M is the largest counter value. `done` is 0 on the edge before that.
- R5: `busy` is 1 from the accepting edge until the edge that raises `done`, and it is 0 from that edge on.
- R6: `start` is ignored while `busy` is 1. The running search keeps its prefix and produces its own result.
- R7: `cfg_load` is ignored while `busy` is 1. The running search keeps its plaintext and ciphertext.
- R8: `done`, `found` and `key` hold their values until the next accepted `start`. The accepting edge clears `done` and `found`.
- R9: The key on the highest engine number with the largest counter value, the last candidate issued, is found and reported.
- R10: A `cfg_load` applied while idle sets the blocks used by the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Loads the plaintext and ciphertext blocks when idle |
| cfg_plain | input | 64 | Known plaintext block |
| cfg_cipher | input | 64 | Target ciphertext block |
| start | input | 1 | Starts a search when idle |
| prefix | input | PREFIX_W | Upper key bits for the search |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until the next accepted start |
| found | output | 1 | A matching key was found |
| key | output | 56 | Matching 56-bit key (valid when found) |

## Verification
The result of every search is due on a cycle fixed by the requirements. The bench takes the edge that accepts `start` as edge 0 and predicts the match at edge 19+c, where c is the counter value of the key being sought. A not-found result is due at edge 19+M. The bench counts rising edges from edge 0 and samples on the falling edge. It checks that `done` is still low one edge early and that `done`, `found` and `key` are correct exactly on the due edge. Stray `start` and `cfg_load` pulses are placed at known edges inside a running search, and the due result must still carry the original search's key.

// File: rtl/dks_pkg.sv
// Package dks_pkg
// Shared constants and pure functions for the DES key searcher: the
// standard DES permutation and substitution tables, the key expansion with
// parity, the per-round subkey and the Feistel round function.
// Assumes DES bit 1 is the most significant bit of each vector.
package dks_pkg;

    localparam int KEY_W = 56;
    localparam int BLK_W = 64;
    localparam int ROUNDS = 16;

    localparam int T_IP [64] = '{
        58, 50, 42, 34, 26, 18, 10,  2, 60, 52, 44, 36, 28, 20, 12,  4,
        62, 54, 46, 38, 30, 22, 14,  6, 64, 56, 48, 40, 32, 24, 16,  8,
        57, 49, 41, 33, 25, 17,  9,  1, 59, 51, 43, 35, 27, 19, 11,  3,
        61, 53, 45, 37, 29, 21, 13,  5, 63, 55, 47, 39, 31, 23, 15,  7};

    localparam int T_FP [64] = '{
        40,  8, 48, 16, 56, 24, 64, 32, 39,  7, 47, 15, 55, 23, 63, 31,
        38,  6, 46, 14, 54, 22, 62, 30, 37,  5, 45, 13, 53, 21, 61, 29,
        36,  4, 44, 12, 52, 20, 60, 28, 35,  3, 43, 11, 51, 19, 59, 27,
        34,  2, 42, 10, 50, 18, 58, 26, 33,  1, 41,  9, 49, 17, 57, 25};

    localparam int T_E [48] = '{
        32,  1,  2,  3,  4,  5,  4,  5,  6,  7,  8,  9,
         8,  9, 10, 11, 12, 13, 12, 13, 14, 15, 16, 17,
        16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
        24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32,  1};

    localparam int T_P [32] = '{
        16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

    localparam int T_PC1 [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

    localparam int T_PC2 [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    // Total left rotation of each key half before round r (index r-1).
    localparam int T_ROT [16] = '{1, 2, 4, 6, 8, 10, 12, 14, 15, 17, 19, 21, 23, 25, 27, 28};

    localparam int T_S1 [64] = '{
        14,  4, 13,  1,  2, 15, 11,  8,  3, 10,  6, 12,  5,  9,  0,  7,
         0, 15,  7,  4, 14,  2, 13,  1, 10,  6, 12, 11,  9,  5,  3,  8,
         4,  1, 14,  8, 13,  6,  2, 11, 15, 12,  9,  7,  3, 10,  5,  0,
        15, 12,  8,  2,  4,  9,  1,  7,  5, 11,  3, 14, 10,  0,  6, 13};
    localparam int T_S2 [64] = '{
        15,  1,  8, 14,  6, 11,  3,  4,  9,  7,  2, 13, 12,  0,  5, 10,
         3, 13,  4,  7, 15,  2,  8, 14, 12,  0,  1, 10,  6,  9, 11,  5,
         0, 14,  7, 11, 10,  4, 13,  1,  5,  8, 12,  6,  9,  3,  2, 15,
        13,  8, 10,  1,  3, 15,  4,  2, 11,  6,  7, 12,  0,  5, 14,  9};
    localparam int T_S3 [64] = '{
        10,  0,  9, 14,  6,  3, 15,  5,  1, 13, 12,  7, 11,  4,  2,  8,
        13,  7,  0,  9,  3,  4,  6, 10,  2,  8,  5, 14, 12, 11, 15,  1,
        13,  6,  4,  9,  8, 15,  3,  0, 11,  1,  2, 12,  5, 10, 14,  7,
         1, 10, 13,  0,  6,  9,  8,  7,  4, 15, 14,  3, 11,  5,  2, 12};
    localparam int T_S4 [64] = '{
         7, 13, 14,  3,  0,  6,  9, 10,  1,  2,  8,  5, 11, 12,  4, 15,
        13,  8, 11,  5,  6, 15,  0,  3,  4,  7,  2, 12,  1, 10, 14,  9,
        10,  6,  9,  0, 12, 11,  7, 13, 15,  1,  3, 14,  5,  2,  8,  4,
         3, 15,  0,  6, 10,  1, 13,  8,  9,  4,  5, 11, 12,  7,  2, 14};
    localparam int T_S5 [64] = '{
         2, 12,  4,  1,  7, 10, 11,  6,  8,  5,  3, 15, 13,  0, 14,  9,
        14, 11,  2, 12,  4,  7, 13,  1,  5,  0, 15, 10,  3,  9,  8,  6,
         4,  2,  1, 11, 10, 13,  7,  8, 15,  9, 12,  5,  6,  3,  0, 14,
        11,  8, 12,  7,  1, 14,  2, 13,  6, 15,  0,  9, 10,  4,  5,  3};
    localparam int T_S6 [64] = '{
        12,  1, 10, 15,  9,  2,  6,  8,  0, 13,  3,  4, 14,  7,  5, 11,
        10, 15,  4,  2,  7, 12,  9,  5,  6,  1, 13, 14,  0, 11,  3,  8,
         9, 14, 15,  5,  2,  8, 12,  3,  7,  0,  4, 10,  1, 13, 11,  6,
         4,  3,  2, 12,  9,  5, 15, 10, 11, 14,  1,  7,  6,  0,  8, 13};
    localparam int T_S7 [64] = '{
         4, 11,  2, 14, 15,  0,  8, 13,  3, 12,  9,  7,  5, 10,  6,  1,
        13,  0, 11,  7,  4,  9,  1, 10, 14,  3,  5, 12,  2, 15,  8,  6,
         1,  4, 11, 13, 12,  3,  7, 14, 10, 15,  6,  8,  0,  5,  9,  2,
         6, 11, 13,  8,  1,  4, 10,  7,  9,  5,  0, 15, 14,  2,  3, 12};
    localparam int T_S8 [64] = '{
        13,  2,  8,  4,  6, 15, 11,  1, 10,  9,  3, 14,  5,  0, 12,  7,
         1, 15, 13,  8, 10,  3,  7,  4, 12,  5,  6, 11,  0, 14,  9,  2,
         7, 11,  4,  1,  9, 12, 14,  2,  0,  6, 10, 13, 15,  3,  5,  8,
         2,  1, 14,  7,  4, 10,  8, 13, 15, 12,  9,  0,  3,  5,  6, 11};

    // Initial permutation of a block.
    function automatic logic [63:0] perm_ip(input logic [63:0] x);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[63-i] = x[64-T_IP[i]];
        return r;
    endfunction

    // Final permutation of a block.
    function automatic logic [63:0] perm_fp(input logic [63:0] x);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[63-i] = x[64-T_FP[i]];
        return r;
    endfunction

    // Expansion of a 32-bit half to 48 bits.
    function automatic logic [47:0] perm_e(input logic [31:0] x);
        logic [47:0] r;
        for (int i = 0; i < 48; i++) r[47-i] = x[32-T_E[i]];
        return r;
    endfunction

    // Permutation of the substitution output.
    function automatic logic [31:0] perm_p(input logic [31:0] x);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = x[32-T_P[i]];
        return r;
    endfunction

    // Key selection from the 64-bit key down to 56 bits.
    function automatic logic [55:0] perm_pc1(input logic [63:0] x);
        logic [55:0] r;
        for (int i = 0; i < 56; i++) r[55-i] = x[64-T_PC1[i]];
        return r;
    endfunction

    // Subkey selection from the rotated halves.
    function automatic logic [47:0] perm_pc2(input logic [55:0] x);
        logic [47:0] r;
        for (int i = 0; i < 48; i++) r[47-i] = x[56-T_PC2[i]];
        return r;
    endfunction

    // Left rotation of a 28-bit key half.
    function automatic logic [27:0] rotl28(input logic [27:0] c, input int n);
        return (c << n) | (c >> (28 - n));
    endfunction

    // Widen a 56-bit key to 64 bits with an odd-parity bit at the bottom of each byte.
    function automatic logic [63:0] add_parity(input logic [55:0] k);
        logic [63:0] r;
        logic [6:0]  seven;
        for (int i = 0; i < 8; i++) begin
            seven = k[55-7*i -: 7];
            r[63-8*i -: 8] = {seven, ~^seven};
        end
        return r;
    endfunction

    // Subkey used in round rnd (1..16) for a given 56-bit key.
    function automatic logic [47:0] subkey(input logic [55:0] k, input int rnd);
        logic [55:0] cd;
        cd = perm_pc1(add_parity(k));
        return perm_pc2({rotl28(cd[55:28], T_ROT[rnd-1]), rotl28(cd[27:0], T_ROT[rnd-1])});
    endfunction

    // Lookup in substitution box idx (0..7); row from outer bits, column from inner.
    function automatic logic [3:0] sbox(input int idx, input logic [5:0] b);
        int ent;
        logic [3:0] v;
        ent = int'({b[5], b[0], b[4:1]});
        case (idx)
            0: v = 4'(T_S1[ent]);
            1: v = 4'(T_S2[ent]);
            2: v = 4'(T_S3[ent]);
            3: v = 4'(T_S4[ent]);
            4: v = 4'(T_S5[ent]);
            5: v = 4'(T_S6[ent]);
            6: v = 4'(T_S7[ent]);
            default: v = 4'(T_S8[ent]);
        endcase
        return v;
    endfunction

    // Round function applied to the right half.
    function automatic logic [31:0] feistel(input logic [31:0] r, input logic [47:0] k);
        logic [47:0] e;
        logic [31:0] s;
        e = perm_e(r) ^ k;
        for (int j = 0; j < 8; j++) s[31-4*j -: 4] = sbox(j, e[47-6*j -: 6]);
        return perm_p(s);
    endfunction

endpackage

// File: rtl/dks_keygen.sv
// Module dks_keygen
// Search sequencer: holds the busy state and the shared candidate counter
// that all engines step together. Issues one counter value per clock from 0
// up to the maximum, then stops; a finish from the resolver ends it early.
// Assumes start_acc is only raised while idle.
module dks_keygen #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             finish,
    output logic             busy,
    output logic             issue,
    output logic             issue_last,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Busy flag, issue window and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            issue <= 1'b0;
            cnt   <= '0;
        end else if (start_acc) begin
            busy  <= 1'b1;
            issue <= 1'b1;
            cnt   <= '0;
        end else if (finish) begin
            busy  <= 1'b0;
            issue <= 1'b0;
        end else if (issue) begin
            if (cnt == CNT_MAX) issue <= 1'b0;
            else                cnt   <= cnt + 1'b1;
        end
    end

    // Marks the final candidate so the pipelines can carry a drain tag.
    assign issue_last = issue && (cnt == CNT_MAX);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !finish && !start_acc && !issue_last) |=> (cnt == $past(cnt) + 1'b1));

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

endmodule

// File: rtl/dks_round.sv
// Module dks_round
// One registered DES round. Derives its own subkey from the key that rides
// along with the block, applies the Feistel step and passes key, valid and
// drain tag to the next stage. Flush clears valid and tag.
module dks_round #(
    parameter int RND = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        v_in,
    input  logic        last_in,
    input  logic [55:0] key_in,
    input  logic [63:0] lr_in,
    output logic        v_out,
    output logic        last_out,
    output logic [55:0] key_out,
    output logic [63:0] lr_out
);
    logic [47:0] sk;

    // Subkey for this round position.
    assign sk = dks_pkg::subkey(key_in, RND);

    // Valid and drain tag, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            v_out    <= 1'b0;
            last_out <= 1'b0;
        end else begin
            v_out    <= v_in;
            last_out <= last_in;
        end
    end

    // Feistel step and key carry.
    always_ff @(posedge clk) begin
        key_out <= key_in;
        lr_out  <= {lr_in[31:0], lr_in[63:32] ^ dks_pkg::feistel(lr_in[31:0], sk)};
    end

endmodule

// File: rtl/dks_engine.sv
// Module dks_engine
// One 18-stage DES encryption pipeline: input register (initial
// permutation), sixteen round stages, output register (swap and final
// permutation). The candidate key travels alongside the block, so the output
// key is the one that produced the output block.
module dks_engine (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        v_in,
    input  logic        last_in,
    input  logic [55:0] key_in,
    input  logic [63:0] pt_in,
    output logic        v_out,
    output logic        last_out,
    output logic [55:0] key_out,
    output logic [63:0] blk_out
);
    localparam int NR = dks_pkg::ROUNDS;

    logic        st0_v, st0_last;
    logic [55:0] st0_key;
    logic [63:0] st0_lr;

    logic [NR:0]       v_s, l_s;
    logic [NR:0][55:0] key_s;
    logic [NR:0][63:0] lr_s;

    // Input stage valid and tag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            st0_v    <= 1'b0;
            st0_last <= 1'b0;
        end else begin
            st0_v    <= v_in;
            st0_last <= last_in;
        end
    end

    // Input stage data: key capture and initial permutation.
    always_ff @(posedge clk) begin
        st0_key <= key_in;
        st0_lr  <= dks_pkg::perm_ip(pt_in);
    end

    assign v_s[0]   = st0_v;
    assign l_s[0]   = st0_last;
    assign key_s[0] = st0_key;
    assign lr_s[0]  = st0_lr;

    for (genvar g = 1; g <= NR; g++) begin : g_round
        dks_round #(.RND(g)) u_round (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .v_in    (v_s[g-1]),
            .last_in (l_s[g-1]),
            .key_in  (key_s[g-1]),
            .lr_in   (lr_s[g-1]),
            .v_out   (v_s[g]),
            .last_out(l_s[g]),
            .key_out (key_s[g]),
            .lr_out  (lr_s[g])
        );
    end

    // Output stage valid and tag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            v_out    <= 1'b0;
            last_out <= 1'b0;
        end else begin
            v_out    <= v_s[NR];
            last_out <= l_s[NR];
        end
    end

    // Output stage data: half swap and final permutation.
    always_ff @(posedge clk) begin
        key_out <= key_s[NR];
        blk_out <= dks_pkg::perm_fp({lr_s[NR][31:0], lr_s[NR][63:32]});
    end

    assert_last_rides_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_out |-> v_out);

endmodule

// File: rtl/dks_resolve.sv
// Module dks_resolve
// Compares every engine output with the target ciphertext, picks the lowest
// matching engine, and holds done / found / key until the next accepted
// start. Declares not-found when the drain-tagged last candidate leaves
// the pipelines without a match. Assumes all engines run in lockstep.
module dks_resolve #(
    parameter int N_ENG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_acc,
    input  logic                   busy,
    input  logic [63:0]            target,
    input  logic [N_ENG-1:0]       v_o,
    input  logic [N_ENG-1:0]       last_o,
    input  logic [N_ENG-1:0][55:0] key_o,
    input  logic [N_ENG-1:0][63:0] blk_o,
    output logic                   finish,
    output logic                   done,
    output logic                   found,
    output logic [55:0]            key
);
    logic [N_ENG-1:0] hit;
    logic [55:0]      sel_key;
    logic             hit_any, drained;

    // Per-engine match and lowest-index key select.
    always_comb begin
        sel_key = '0;
        for (int e = 0; e < N_ENG; e++) hit[e] = v_o[e] && (blk_o[e] == target);
        for (int e = N_ENG - 1; e >= 0; e--) if (hit[e]) sel_key = key_o[e];
    end

    assign hit_any = |hit;
    assign drained = &(v_o & last_o);
    assign finish  = busy && (hit_any || drained);

    // Result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            found <= 1'b0;
            key   <= '0;
        end else if (start_acc) begin
            done  <= 1'b0;
            found <= 1'b0;
        end else if (busy && hit_any) begin
            done  <= 1'b1;
            found <= 1'b1;
            key   <= sel_key;
        end else if (busy && drained) begin
            done  <= 1'b1;
        end
    end

    assert_found_has_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_acc) |=> (done && $stable(found) && $stable(key)));

endmodule

// File: rtl/des_key_searcher.sv
// Module des_key_searcher
// Top of the known-plaintext DES key searcher. Holds the plaintext, target
// ciphertext and prefix, forms each engine's candidate key as
// {prefix, engine number, counter}, and connects sequencer, engines and
// resolver. Assumes N_ENG is a power of two of at least 2 and that
// PREFIX_W + LOW_W equals 56.
module des_key_searcher #(
    parameter int PREFIX_W = 24,
    parameter int LOW_W    = 32,
    parameter int N_ENG    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [63:0]         cfg_plain,
    input  logic [63:0]         cfg_cipher,
    input  logic                start,
    input  logic [PREFIX_W-1:0] prefix,
    output logic                busy,
    output logic                done,
    output logic                found,
    output logic [55:0]         key
);
    localparam int ID_W  = $clog2(N_ENG);
    localparam int CNT_W = LOW_W - ID_W;

    logic [63:0]         pt_q, ct_q;
    logic [PREFIX_W-1:0] prefix_q;
    logic                start_acc, finish, flush;
    logic                issue, issue_last;
    logic [CNT_W-1:0]    cnt;

    logic [N_ENG-1:0]       v_o, last_o;
    logic [N_ENG-1:0][55:0] key_o;
    logic [N_ENG-1:0][63:0] blk_o;

    assign start_acc = start && !busy;
    assign flush     = start_acc || finish;

    // Known blocks, loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
            ct_q <= '0;
        end else if (cfg_load && !busy) begin
            pt_q <= cfg_plain;
            ct_q <= cfg_cipher;
        end
    end

    // Prefix captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)         prefix_q <= '0;
        else if (start_acc) prefix_q <= prefix;
    end

    dks_keygen #(.CNT_W(CNT_W)) u_keygen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .finish    (finish),
        .busy      (busy),
        .issue     (issue),
        .issue_last(issue_last),
        .cnt       (cnt)
    );

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        logic [55:0] cand;
        assign cand = {prefix_q, ID_W'(e), cnt};

        dks_engine u_engine (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .v_in    (issue),
            .last_in (issue_last),
            .key_in  (cand),
            .pt_in   (pt_q),
            .v_out   (v_o[e]),
            .last_out(last_o[e]),
            .key_out (key_o[e]),
            .blk_out (blk_o[e])
        );
    end

    dks_resolve #(.N_ENG(N_ENG)) u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_acc(start_acc),
        .busy     (busy),
        .target   (ct_q),
        .v_o      (v_o),
        .last_o   (last_o),
        .key_o    (key_o),
        .blk_o    (blk_o),
        .finish   (finish),
        .done     (done),
        .found    (found),
        .key      (key)
    );

    assert_prefix_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(prefix_q));

    assert_target_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> ($stable(ct_q) && $stable(pt_q)));

endmodule

// File: tb/des_key_searcher_bench.sv
// Directed bench for des_key_searcher with a short low field (12 bits,
// 9-bit counters) so complete sweeps fit in a few hundred cycles.
module des_key_searcher_bench;
    localparam int PW = 44;
    localparam int LW = 12;
    localparam int NE = 8;
    localparam int MAXC = 511;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [63:0]   cfg_plain = '0;
    logic [63:0]   cfg_cipher = '0;
    logic          start = 1'b0;
    logic [PW-1:0] prefix = '0;
    logic          busy, done, found;
    logic [55:0]   key;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] PT_A = 64'h0123456789ABCDEF;
    localparam logic [63:0] CT_A = 64'h85E813540F0AB405;
    localparam logic [55:0] K_A  = 56'h12695BC9B7B7F8;
    localparam logic [63:0] CT_Z = 64'h8CA64DE9C1B123A7;
    localparam logic [63:0] CT_F = 64'h7359B2163E4EDC58;

    always #2 clk = ~clk;

    des_key_searcher #(.PREFIX_W(PW), .LOW_W(LW), .N_ENG(NE)) u_des_key_searcher (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_plain(cfg_plain),
        .cfg_cipher(cfg_cipher), .start(start), .prefix(prefix),
        .busy(busy), .done(done), .found(found), .key(key)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [63:0] p, input logic [63:0] c);
        cfg_load = 1'b1; cfg_plain = p; cfg_cipher = c;
        step(1);
        cfg_load = 1'b0;
    endtask

    // Ends at the falling edge after the accepting edge (edge 0).
    task automatic begin_search(input logic [PW-1:0] p);
        start = 1'b1; prefix = p;
        step(1);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(1);
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(found == 1'b0, "R1", "found after reset", 64'(found), 64'd0);
    endtask

    // Match in engine 3 at counter 504; stray start at edge 11 (R6).
    task automatic t_mid_key();
        load_cfg(PT_A, CT_A);
        begin_search(K_A[55:12]);
        check(busy == 1'b1, "R5", "busy after accept", 64'(busy), 64'd1);
        step(10);
        start = 1'b1; prefix = 44'h0000000ABCD;
        step(1);
        start = 1'b0;
        step(522 - 11);
        check(done == 1'b0, "R3", "done one edge early", 64'(done), 64'd0);
        check(busy == 1'b1, "R5", "busy one edge early", 64'(busy), 64'd1);
        step(1);
        check(done == 1'b1 && found == 1'b1, "R3", "done/found on due edge",
              64'({done, found}), 64'd3);
        check(key == K_A, "R2", "reported key", 64'(key), 64'(K_A));
        check(key == K_A, "R6", "stray start did not change prefix", 64'(key), 64'(K_A));
        check(busy == 1'b0, "R5", "busy cleared with done", 64'(busy), 64'd0);
    endtask

    // Result holds, then a restart clears it; the restart runs to not-found (R4).
    task automatic t_hold_and_miss();
        step(20);
        check(done == 1'b1 && found == 1'b1 && key == K_A, "R8", "result held",
              64'(key), 64'(K_A));
        begin_search(44'h12695BC9B7A);
        check(done == 1'b0 && found == 1'b0, "R8", "accepted start clears result",
              64'({done, found}), 64'd0);
        step(18 + MAXC);
        check(done == 1'b0, "R4", "not-found one edge early", 64'(done), 64'd0);
        step(1);
        check(done == 1'b1, "R4", "not-found done", 64'(done), 64'd1);
        check(found == 1'b0, "R4", "not-found flag", 64'(found), 64'd0);
    endtask

    // All-zero key on engine 0 counter 0; idle load (R10), busy load (R7).
    task automatic t_zero_key();
        load_cfg(64'h0, CT_Z);
        begin_search('0);
        step(2);
        cfg_load = 1'b1; cfg_plain = PT_A; cfg_cipher = CT_A;
        step(1);
        cfg_load = 1'b0;
        step(18 - 3);
        check(done == 1'b0, "R3", "zero key one edge early", 64'(done), 64'd0);
        step(1);
        check(done == 1'b1 && found == 1'b1, "R10", "idle load used by search",
              64'({done, found}), 64'd3);
        check(found == 1'b1, "R7", "busy load ignored", 64'(found), 64'd1);
        check(key == 56'h0, "R2", "zero key value", 64'(key), 64'd0);
    endtask

    // Highest engine, largest counter: the final candidate.
    task automatic t_last_key();
        load_cfg(64'hFFFFFFFFFFFFFFFF, CT_F);
        begin_search({PW{1'b1}});
        step(18 + MAXC);
        check(done == 1'b0, "R9", "last key one edge early", 64'(done), 64'd0);
        step(1);
        check(done == 1'b1 && found == 1'b1, "R9", "last key found",
              64'({done, found}), 64'd3);
        check(key == {56{1'b1}}, "R9", "last key value", 64'(key), 64'(56'hFFFFFFFFFFFFFF));
    endtask

    initial begin
        t_reset();
        t_mid_key();
        t_hold_and_miss();
        t_zero_key();
        t_last_key();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule